// File: doc/BRIEF.md
# Interrupt Controller Command Port Decoder

This block is the byte-wide, two-address programming interface of a single eight-line priority interrupt controller. Software writes initialization words to walk the controller through its setup sequence. After that, operation words set the line mask, choose what a status read returns, switch the special mask and poll modes, and issue end-of-interrupt and priority-rotation commands. The block holds the programmed configuration and drives it out to the rest of the controller.

The block does not resolve priority, and it does not own the in-service or request registers. Those registers and the rotation offset are inputs from the resolver. In return, the block sends the resolver one-cycle pulses: an end-of-interrupt pulse that carries the line to clear, a rotation pulse that carries the new lowest-priority base, and an initialization pulse that tells the resolver to clear its own state. When a non-specific end-of-interrupt arrives, the block searches the in-service vector in rotated priority order. It starts at the current offset, so line numbers are compared modulo eight.

Reads are combinational while the read strobe is high. The odd address returns the mask. The even address returns the poll word when poll mode is armed. Otherwise it returns the in-service or request vector, whichever was last selected.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, vector base, nested-mode, auto-EOI, rotate-on-auto-EOI, special-mask and read-select flags are all zero, the block is in normal mode (`in_init_o` = 0), and an even read returns the request vector.
- R2: An even-address write with data bit 4 set starts initialization. One cycle later `init_o` pulses, `in_init_o` is 1, and the mask and all mode flags are cleared.
- R3: An initialization-start word with data bit 1 (single controller) or data bit 3 (level triggering) set raises `cfg_err_o` for one cycle. A start word with both bits clear leaves it low.
- R4: During initialization, odd-address writes never touch the mask. The first one loads the vector base as data with bits 2:0 forced to zero. The second one is consumed. The block then returns to normal mode, unless bit 0 of the start word asked for a fourth word, in which case it returns after that fourth word.
- R5: The fourth initialization word sets special fully nested mode from data bit 4 and auto-EOI from data bit 1.
- R6: In normal mode an odd-address write loads the mask, and an odd-address read returns it.
- R7: An even write with bit 4 clear and bit 3 set is a mode word. If its bit 1 is set, bit 0 selects the status read: 1 gives the in-service vector and 0 gives the request vector. If bit 1 is clear, the selection is unchanged.
- R8: In a mode word, bit 6 set makes bit 5 the new special-mask flag. If bit 6 is clear, the flag is unchanged.
- R9: A mode word with bit 2 set arms poll mode. The next even read returns 0x80 OR the winning line when a request is pending, and 0x00 when none is pending. That read disarms poll mode.
- R10: An even write with bits 4 and 3 clear is a command word, and bits 7:5 give the command code. Codes 0 and 4 load rotate-on-auto-EOI from bit 7.
- R11: Code 1 (non-specific EOI) pulses `eoi_o` with the first set in-service line, searching upward from `prio_off_i` and wrapping modulo 8. If no line is in service, there is no pulse.
- R12: Code 5 does the same as code 1 and also pulses `rot_o` with `rot_off_o` = (cleared line + 1) mod 8.
- R13: Code 3 pulses `eoi_o` for line data[2:0]. Code 7 does the same and also rotates to (data[2:0] + 1) mod 8. Code 6 only rotates, to (data[2:0] + 1) mod 8. Code 2 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register address bit (0 even, 1 odd) |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| isr_i | input | 8 | In-service vector from the resolver |
| irr_i | input | 8 | Request vector from the resolver |
| prio_off_i | input | 3 | Current lowest-priority base from the resolver |
| req_vld_i | input | 1 | Resolver has a winning request |
| req_line_i | input | 3 | Winning request line |
| rdata_o | output | 8 | Read data, zero when `rd_i` is low |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| in_init_o | output | 1 | Initialization sequence in progress |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto-EOI mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| spec_mask_o | output | 1 | Special mask mode |
| read_isr_o | output | 1 | Status read selects the in-service vector |
| init_o | output | 1 | One-cycle pulse: clear resolver state |
| cfg_err_o | output | 1 | Unsupported initialization mode requested |
| eoi_o | output | 1 | One-cycle pulse: clear an in-service bit |
| eoi_line_o | output | 3 | Line to clear with `eoi_o` |
| rot_o | output | 1 | One-cycle pulse: load a new priority base |
| rot_off_o | output | 3 | New priority base with `rot_o` |

## Verification
The bench uses the default parameters: eight lines, eight-bit data, and `ERR_STICKY` = 0. With eight lines, the rotated end-of-interrupt search can wrap past line 7, and the bench covers both a search that wraps and one that does not. With `ERR_STICKY` = 0, the error flag is a pulse, so the bench can see it rise on a bad start word and fall again on a clean one. The sticky variant of the error flag is not built by this bench.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

   typedef enum logic [1:0] {
      STEP_RUN  = 2'd0,
      STEP_BASE = 2'd1,
      STEP_CASC = 2'd2,
      STEP_MODE = 2'd3
   } init_step_t;

   typedef enum logic [2:0] {
      CMD_RAEOI_CLR = 3'd0,
      CMD_NS_EOI    = 3'd1,
      CMD_NOP       = 3'd2,
      CMD_SP_EOI    = 3'd3,
      CMD_RAEOI_SET = 3'd4,
      CMD_NS_EOI_R  = 3'd5,
      CMD_SET_PRIO  = 3'd6,
      CMD_SP_EOI_R  = 3'd7
   } ocw_cmd_t;

endpackage

// File: rtl/pic_rot_scan.sv
module pic_rot_scan #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LW = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] vec_i,
   input  logic [LW-1:0]        base_i,
   output logic                 hit_o,
   output logic [LW-1:0]        line_o
);

   generate
      if ((1 << LW) != NUM_LINES) begin : g_bad_lines
         $error("pic_rot_scan: NUM_LINES must be a power of two");
      end
   endgenerate

   logic [LW-1:0] idx;

   always_comb begin
      hit_o  = |vec_i;
      line_o = '0;
      idx    = '0;
      for (int k = NUM_LINES - 1; k >= 0; k--) begin
         idx = base_i + LW'(k);
         if (vec_i[idx]) line_o = idx;
      end
   end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_cmd_pkg::*;
#(
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       odd_wr_i,
   input  logic [4:0] d_hi_i,
   input  logic [1:0] d_lo_i,
   output logic       run_o,
   output logic [7:0] vec_base_o,
   output logic       sfnm_o,
   output logic       aeoi_o,
   output logic       init_o,
   output logic       err_o
);

   init_step_t step_q;
   logic       need_mode_q;
   logic       bad_mode;

   assign bad_mode = d_lo_i[1] | d_hi_i[0];
   assign run_o    = (step_q == STEP_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q      <= STEP_RUN;
         need_mode_q <= 1'b0;
         vec_base_o  <= '0;
         sfnm_o      <= 1'b0;
         aeoi_o      <= 1'b0;
         init_o      <= 1'b0;
      end else begin
         init_o <= start_i;
         if (start_i) begin
            step_q      <= STEP_BASE;
            need_mode_q <= d_lo_i[0];
            sfnm_o      <= 1'b0;
            aeoi_o      <= 1'b0;
         end else if (odd_wr_i) begin
            unique case (step_q)
               STEP_BASE: begin
                  vec_base_o <= {d_hi_i, 3'b000};
                  step_q     <= STEP_CASC;
               end
               STEP_CASC: step_q <= need_mode_q ? STEP_MODE : STEP_RUN;
               STEP_MODE: begin
                  sfnm_o <= d_hi_i[1];
                  aeoi_o <= d_lo_i[1];
                  step_q <= STEP_RUN;
               end
               default: step_q <= STEP_RUN;
            endcase
         end
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= err_o | (start_i & bad_mode);
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= start_i & bad_mode;
         end
      end
   endgenerate

   // R2
   start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!run_o && init_o));

   // R4
   leave_on_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> $past(odd_wr_i));

endmodule

// File: rtl/pic_ocw_exec.sv
module pic_ocw_exec
   import pic_cmd_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned LW = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 ocw2_i,
   input  logic                 ocw3_i,
   input  logic                 mask_wr_i,
   input  logic                 poll_rd_i,
   input  logic [2:0]           cmd_i,
   input  logic [2:0]           lo_i,
   input  logic [NUM_LINES-1:0] mask_d_i,
   input  logic [NUM_LINES-1:0] isr_i,
   input  logic [LW-1:0]        prio_off_i,
   output logic [NUM_LINES-1:0] mask_o,
   output logic                 rot_aeoi_o,
   output logic                 spec_mask_o,
   output logic                 read_isr_o,
   output logic                 poll_o,
   output logic                 eoi_o,
   output logic [LW-1:0]        eoi_line_o,
   output logic                 rot_o,
   output logic [LW-1:0]        rot_off_o
);

   logic          scan_hit;
   logic [LW-1:0] scan_line;
   logic [LW-1:0] lo_line;

   assign lo_line = lo_i[LW-1:0];

   pic_rot_scan #(.NUM_LINES(NUM_LINES)) u_scan (
      .vec_i  (isr_i),
      .base_i (prio_off_i),
      .hit_o  (scan_hit),
      .line_o (scan_line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o      <= '0;
         rot_aeoi_o  <= 1'b0;
         spec_mask_o <= 1'b0;
         read_isr_o  <= 1'b0;
         poll_o      <= 1'b0;
         eoi_o       <= 1'b0;
         eoi_line_o  <= '0;
         rot_o       <= 1'b0;
         rot_off_o   <= '0;
      end else begin
         eoi_o <= 1'b0;
         rot_o <= 1'b0;
         if (poll_rd_i) poll_o <= 1'b0;
         if (start_i) begin
            mask_o      <= '0;
            rot_aeoi_o  <= 1'b0;
            spec_mask_o <= 1'b0;
            read_isr_o  <= 1'b0;
            poll_o      <= 1'b0;
         end else if (mask_wr_i) begin
            mask_o <= mask_d_i;
         end else if (ocw3_i) begin
            if (lo_i[1]) read_isr_o  <= lo_i[0];
            if (cmd_i[1]) spec_mask_o <= cmd_i[0];
            if (lo_i[2]) poll_o      <= 1'b1;
         end else if (ocw2_i) begin
            unique case (ocw_cmd_t'(cmd_i))
               CMD_RAEOI_CLR, CMD_RAEOI_SET: rot_aeoi_o <= cmd_i[2];
               CMD_NS_EOI, CMD_NS_EOI_R: begin
                  if (scan_hit) begin
                     eoi_o      <= 1'b1;
                     eoi_line_o <= scan_line;
                     rot_o      <= cmd_i[2];
                     rot_off_o  <= scan_line + 1'b1;
                  end
               end
               CMD_SP_EOI, CMD_SP_EOI_R: begin
                  eoi_o      <= 1'b1;
                  eoi_line_o <= lo_line;
                  rot_o      <= cmd_i[2];
                  rot_off_o  <= lo_line + 1'b1;
               end
               CMD_SET_PRIO: begin
                  rot_o     <= 1'b1;
                  rot_off_o <= lo_line + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R11
   ns_eoi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_i && cmd_i == 3'd1) |=> (eoi_o == $past(|isr_i) && !rot_o));

   // R12
   rot_follows_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_i && cmd_i == 3'd5 && |isr_i) |=> (rot_o && eoi_o && rot_off_o == LW'(eoi_line_o + 1'b1)));

   // R13
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocw2_i && cmd_i == 3'd2) |=> (!eoi_o && !rot_o));

   // R9
   poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_rd_i && !ocw3_i) |=> !poll_o);

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port #(
   parameter int unsigned NUM_LINES  = 8,
   parameter int unsigned DATA_W     = 8,
   parameter bit          ERR_STICKY = 1'b0,
   localparam int unsigned LW = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_i,
   input  logic                 wr_i,
   input  logic                 rd_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [NUM_LINES-1:0] isr_i,
   input  logic [NUM_LINES-1:0] irr_i,
   input  logic [LW-1:0]        prio_off_i,
   input  logic                 req_vld_i,
   input  logic [LW-1:0]        req_line_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [NUM_LINES-1:0] mask_o,
   output logic [DATA_W-1:0]    vec_base_o,
   output logic                 in_init_o,
   output logic                 sfnm_o,
   output logic                 aeoi_o,
   output logic                 rot_aeoi_o,
   output logic                 spec_mask_o,
   output logic                 read_isr_o,
   output logic                 init_o,
   output logic                 cfg_err_o,
   output logic                 eoi_o,
   output logic [LW-1:0]        eoi_line_o,
   output logic                 rot_o,
   output logic [LW-1:0]        rot_off_o
);

   generate
      if (NUM_LINES != 8) begin : g_bad_lines
         $error("pic_cmd_port: command encodings assume eight lines");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("pic_cmd_port: command encodings assume byte data");
      end
   endgenerate

   logic wr_even, wr_odd, start, ocw2, ocw3, run, poll, poll_rd;
   logic [DATA_W-1:0] poll_word;

   assign wr_even = wr_i & ~addr_i;
   assign wr_odd  = wr_i &  addr_i;
   assign start   = wr_even &  wdata_i[4];
   assign ocw3    = wr_even & ~wdata_i[4] &  wdata_i[3];
   assign ocw2    = wr_even & ~wdata_i[4] & ~wdata_i[3];
   assign poll_rd = rd_i & ~addr_i & poll;
   assign in_init_o = ~run;

   pic_init_seq #(.ERR_STICKY(ERR_STICKY)) u_init (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .odd_wr_i   (wr_odd),
      .d_hi_i     (wdata_i[7:3]),
      .d_lo_i     (wdata_i[1:0]),
      .run_o      (run),
      .vec_base_o (vec_base_o),
      .sfnm_o     (sfnm_o),
      .aeoi_o     (aeoi_o),
      .init_o     (init_o),
      .err_o      (cfg_err_o)
   );

   pic_ocw_exec #(.NUM_LINES(NUM_LINES)) u_ocw (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .ocw2_i      (ocw2),
      .ocw3_i      (ocw3),
      .mask_wr_i   (wr_odd & run),
      .poll_rd_i   (poll_rd),
      .cmd_i       (wdata_i[7:5]),
      .lo_i        (wdata_i[2:0]),
      .mask_d_i    (wdata_i),
      .isr_i       (isr_i),
      .prio_off_i  (prio_off_i),
      .mask_o      (mask_o),
      .rot_aeoi_o  (rot_aeoi_o),
      .spec_mask_o (spec_mask_o),
      .read_isr_o  (read_isr_o),
      .poll_o      (poll),
      .eoi_o       (eoi_o),
      .eoi_line_o  (eoi_line_o),
      .rot_o       (rot_o),
      .rot_off_o   (rot_off_o)
   );

   always_comb begin
      poll_word = '0;
      if (req_vld_i) begin
         poll_word[DATA_W-1] = 1'b1;
         poll_word[LW-1:0]   = req_line_i;
      end
   end

   always_comb begin
      if (!rd_i)            rdata_o = '0;
      else if (addr_i)      rdata_o = mask_o;
      else if (poll)        rdata_o = poll_word;
      else if (read_isr_o)  rdata_o = isr_i;
      else                  rdata_o = irr_i;
   end

   // R6
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && run) |=> (mask_o == $past(wdata_i)));

   // R4
   mask_hold_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && !run) |=> $stable(mask_o));

endmodule

// File: tb/test_pic_cmd_port.sv
module test_pic_cmd_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
   logic [7:0] wdata_i = '0, isr_i = '0, irr_i = '0;
   logic [2:0] prio_off_i = '0, req_line_i = '0;
   logic       req_vld_i = 1'b0;
   logic [7:0] rdata_o, mask_o, vec_base_o;
   logic       in_init_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, read_isr_o;
   logic       init_o, cfg_err_o, eoi_o, rot_o;
   logic [2:0] eoi_line_o, rot_off_o;

   int n_chk = 0, n_bad = 0;
   logic s_init, s_err, s_eoi, s_rot;
   logic [2:0] s_line, s_off;
   logic [7:0] rv;

   always #2 clk = ~clk;

   pic_cmd_port i_pic_cmd_port (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
      .wdata_i(wdata_i), .isr_i(isr_i), .irr_i(irr_i), .prio_off_i(prio_off_i),
      .req_vld_i(req_vld_i), .req_line_i(req_line_i), .rdata_o(rdata_o),
      .mask_o(mask_o), .vec_base_o(vec_base_o), .in_init_o(in_init_o),
      .sfnm_o(sfnm_o), .aeoi_o(aeoi_o), .rot_aeoi_o(rot_aeoi_o),
      .spec_mask_o(spec_mask_o), .read_isr_o(read_isr_o), .init_o(init_o),
      .cfg_err_o(cfg_err_o), .eoi_o(eoi_o), .eoi_line_o(eoi_line_o),
      .rot_o(rot_o), .rot_off_o(rot_off_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_i = 1'b1;
      @(posedge clk);
      #1;
      wr_i = 1'b0;
      s_init = init_o; s_err = cfg_err_o; s_eoi = eoi_o; s_rot = rot_o;
      s_line = eoi_line_o; s_off = rot_off_o;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      addr_i = a; rd_i = 1'b1;
      #1 v = rdata_o;
      @(posedge clk);
      #1 rd_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 mask", mask_o, 8'h00);
      chk("R1 base", vec_base_o, 8'h00);
      chk("R1 flags", {2'b0, in_init_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, read_isr_o}, 8'h00);
      irr_i = 8'h42; isr_i = 8'h81;
      rd(1'b0, rv);
      chk("R1 even read gives request vector", rv, 8'h42);
   endtask

   task automatic t_init_long;
      wr(1'b1, 8'h5A);
      chk("R6 mask before start", mask_o, 8'h5A);
      wr(1'b0, 8'h11);
      chk("R2 init pulse", {7'b0, s_init}, 8'h01);
      chk("R2 in init", {7'b0, in_init_o}, 8'h01);
      chk("R2 mask cleared", mask_o, 8'h00);
      chk("R3 clean start no error", {7'b0, s_err}, 8'h00);
      wr(1'b1, 8'h47);
      chk("R4 base low bits forced", vec_base_o, 8'h40);
      chk("R4 mask untouched", mask_o, 8'h00);
      wr(1'b1, 8'h00);
      chk("R4 waits for fourth word", {7'b0, in_init_o}, 8'h01);
      wr(1'b1, 8'h12);
      chk("R5 nested and auto-EOI", {6'b0, sfnm_o, aeoi_o}, 8'h03);
      chk("R4 back to normal", {7'b0, in_init_o}, 8'h00);
      chk("R4 mask still clear", mask_o, 8'h00);
   endtask

   task automatic t_init_short;
      wr(1'b0, 8'h10);
      chk("R2 flags cleared", {6'b0, sfnm_o, aeoi_o}, 8'h00);
      wr(1'b1, 8'hF8);
      chk("R4 base", vec_base_o, 8'hF8);
      wr(1'b1, 8'h04);
      chk("R4 normal after cascade word", {7'b0, in_init_o}, 8'h00);
      chk("R5 flags untouched", {6'b0, sfnm_o, aeoi_o}, 8'h00);
   endtask

   task automatic t_err;
      wr(1'b0, 8'h12);
      chk("R3 single mode error", {7'b0, s_err}, 8'h01);
      wr(1'b0, 8'h18);
      chk("R3 level mode error", {7'b0, s_err}, 8'h01);
      wr(1'b0, 8'h10);
      chk("R3 clean start clears", {7'b0, s_err}, 8'h00);
      wr(1'b1, 8'h08);
      wr(1'b1, 8'h00);
   endtask

   task automatic t_mask;
      wr(1'b1, 8'hA5);
      rd(1'b1, rv);
      chk("R6 mask readback", rv, 8'hA5);
   endtask

   task automatic t_ocw3;
      irr_i = 8'h0C; isr_i = 8'h30;
      wr(1'b0, 8'h0B);
      rd(1'b0, rv);
      chk("R7 select in-service", rv, 8'h30);
      wr(1'b0, 8'h09);
      rd(1'b0, rv);
      chk("R7 gate clear keeps select", rv, 8'h30);
      wr(1'b0, 8'h0A);
      rd(1'b0, rv);
      chk("R7 select request", rv, 8'h0C);
      wr(1'b0, 8'h68);
      chk("R8 special mask on", {7'b0, spec_mask_o}, 8'h01);
      wr(1'b0, 8'h28);
      chk("R8 gate clear keeps flag", {7'b0, spec_mask_o}, 8'h01);
      wr(1'b0, 8'h48);
      chk("R8 special mask off", {7'b0, spec_mask_o}, 8'h00);
      chk("R6 mask kept by mode words", mask_o, 8'hA5);
   endtask

   task automatic t_poll;
      req_vld_i = 1'b1; req_line_i = 3'd5;
      wr(1'b0, 8'h0C);
      rd(1'b0, rv);
      chk("R9 poll word", rv, 8'h85);
      rd(1'b0, rv);
      chk("R9 poll disarmed", rv, 8'h0C);
      req_vld_i = 1'b0;
      wr(1'b0, 8'h0C);
      rd(1'b0, rv);
      chk("R9 poll with nothing pending", rv, 8'h00);
   endtask

   task automatic t_ocw2;
      wr(1'b0, 8'h80);
      chk("R10 rotate-on-auto-EOI set", {7'b0, rot_aeoi_o}, 8'h01);
      wr(1'b0, 8'h00);
      chk("R10 rotate-on-auto-EOI clear", {7'b0, rot_aeoi_o}, 8'h00);
      isr_i = 8'h28; prio_off_i = 3'd4;
      wr(1'b0, 8'h20);
      chk("R11 ns-EOI from offset 4", {s_eoi, s_rot, 3'b0, s_line}, 8'h85);
      prio_off_i = 3'd0;
      wr(1'b0, 8'h20);
      chk("R11 ns-EOI from offset 0", {s_eoi, s_rot, 3'b0, s_line}, 8'h83);
      isr_i = 8'h00;
      wr(1'b0, 8'h20);
      chk("R11 ns-EOI with nothing in service", {6'b0, s_eoi, s_rot}, 8'h00);
      isr_i = 8'h28; prio_off_i = 3'd6;
      wr(1'b0, 8'hA0);
      chk("R12 wrap search and rotate", {s_eoi, s_rot, s_off, s_line}, {2'b11, 3'd4, 3'd3});
      wr(1'b0, 8'h66);
      chk("R13 specific EOI", {s_eoi, s_rot, 3'b0, s_line}, 8'h86);
      wr(1'b0, 8'hE7);
      chk("R13 specific EOI rotate", {s_eoi, s_rot, s_off, s_line}, {2'b11, 3'd0, 3'd7});
      wr(1'b0, 8'hC2);
      chk("R13 set priority", {s_eoi, s_rot, 3'b0, s_off}, 8'h43);
      wr(1'b0, 8'h40);
      chk("R13 no-op command", {6'b0, s_eoi, s_rot}, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_init_long;
      t_init_short;
      t_err;
      t_mask;
      t_ocw3;
      t_poll;
      t_ocw2;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule